// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a shared, single-wire serial interrupt line that runs on the bus clock. Each polling cycle has three parts. The host first pulls the line low for a start pulse. A programmable run of three-clock data slots follows, and in each slot one peripheral may pull the line low to report that its request is active. The host then pulls the line low again for a stop pulse, whose length tells the peripherals whether the next cycle starts automatically or only on demand.

The host never drives the line high. It only pulls it low or leaves it to the external pull-up, so the pin is controlled by an output-enable and a constant low data value. The recovered levels of the first sixteen slots are held in a latch. The IRQ0, IRQ1 and SMI levels then pass through a per-output polarity stage. A small write-only configuration register holds every setting.

Top module: `sirq_host`

## Requirements
- R1: When the enable field (configuration bit 0) is 0, `line_oe` stays 0 and a cycle in progress is abandoned. `irq_hi_o` reads 0, and IRQ0, IRQ1 and SMI each show their inactive level, which is the value of their polarity bit.
- R2: With enable set and the mode field (bit 1) at 0, cycles run back to back. The next start pulse begins in the clock after the stop turnaround clock, and the first cycle begins one clock after enable is set.
- R3: With the mode field at 1, the idle host does not drive the line. A new cycle begins in the clock after `poll_req` is seen high.
- R4: A cycle carries 17 + N data slots, where N is the 4-bit slot field (bits 5:2). Each slot is three clocks long, and the host releases the line in all of them. Two released clocks come between the start pulse and the first slot.
- R5: The start pulse lasts 4, 6 or 8 clocks when the width field (bits 7:6) is 00, 01 or 10. The value 11 gives 4 clocks.
- R6: Polarity bits 8, 9 and 10 belong to IRQ0, IRQ1 and SMI in that order. A 0 bit makes the output high when its request is active. A 1 bit inverts the output.
- R7: After reset the register holds zero. The host does not drive the line and all recovered outputs are 0.
- R8: The line level is sampled in the first clock of each slot, and a low level means active. Slot 0 is IRQ0, slot 1 is IRQ1, slot 2 is SMI, and slot k for k from 3 to 15 is IRQ k, shown on `irq_hi_o[k-3]`. Slots from 16 upward affect no output.
- R9: The recovered outputs change only at the end of the last slot of a cycle, and then all of them change together.
- R10: The stop pulse lasts 2 clocks when the mode field reads 1 at the end of the last slot, and 3 clocks when it reads 0. One released clock follows the stop pulse.
- R11: In mode 1, if the idle line is seen low for a clock, the host continues the start pulse for the programmed width minus one clock.
- R12: `line_o` is always 0. The host enables the driver only during start and stop pulses.
- R13: Changes to the slot field and the width field apply from the next start pulse. A cycle already running keeps its slot count and stop timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 11 | Configuration value: enable, mode, slots, width, polarities |
| poll_req | input | 1 | Host request for a cycle in on-demand mode |
| line_i | input | 1 | Sensed level of the serial interrupt line |
| line_oe | output | 1 | Driver enable for the line |
| line_o | output | 1 | Value driven when enabled (always low) |
| irq0_o | output | 1 | Recovered IRQ0 after polarity |
| irq1_o | output | 1 | Recovered IRQ1 after polarity |
| smi_o | output | 1 | Recovered SMI request after polarity |
| irq_hi_o | output | 13 | Recovered IRQ3 to IRQ15, active high |

## Verification
Some properties hold on every clock, and the assertions check those. The host returns to idle once it is disabled. The start pulse is either the full programmed width or one clock short. The stop counter never exceeds three clocks. The slot index stays inside the latched count. No sample is taken while the host drives the line. The latched levels move only at the end of a cycle, and they are cleared while the host is disabled. The bench scenarios cover behaviour that spans whole cycles: the exact pulse widths for each width code, the slot counts of 17 and 32, deferred changes to the settings, the wait for a request in on-demand mode, the start begun by a peripheral, and the mapping from slot to output under both polarities.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int CFG_W       = 11;
    localparam int TRACKED     = 16;
    localparam int BASE_SLOTS  = 17;
    localparam int SLOT_IDX_W  = 5;
    localparam int CNT_W       = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_START_TA,
        ST_SLOT,
        ST_STOP,
        ST_STOP_TA
    } seq_state_e;

    typedef struct packed {
        logic [2:0] pol;     // [0] irq0, [1] irq1, [2] smi
        logic [1:0] width;
        logic [3:0] slots;
        logic       quiet;
        logic       enable;
    } sirq_cfg_t;

    function automatic logic [CNT_W-1:0] start_low_clocks(input logic [1:0] code);
        case (code)
            2'b01:   return CNT_W'(6);
            2'b10:   return CNT_W'(8);
            default: return CNT_W'(4);
        endcase
    endfunction

    function automatic logic [SLOT_IDX_W-1:0] last_slot_index(input logic [3:0] field);
        return SLOT_IDX_W'(BASE_SLOTS - 1) + {1'b0, field};
    endfunction

endpackage

// File: rtl/sirq_cfg_reg.sv
module sirq_cfg_reg
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output sirq_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we)
            cfg <= sirq_cfg_t'(wdata);
    end
endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int TA_CLKS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sirq_cfg_t             cfg,
    input  logic                  line_i,
    input  logic                  poll_req,
    output logic                  drive_low,
    output logic                  sample_stb,
    output logic [SLOT_IDX_W-1:0] sample_idx,
    output logic                  cycle_done
);
    localparam logic [CNT_W-1:0] SLOT_LAST_PH = CNT_W'(2);

    seq_state_e            st_q, st_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic [SLOT_IDX_W-1:0] slot_q, slot_d, last_q, last_d;
    logic [CNT_W-1:0]      wid_q, wid_d;
    logic                  nq_q, nq_d;
    logic [CNT_W-1:0]      w_now;

    assign w_now = start_low_clocks(cfg.width);

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        slot_d     = slot_q;
        last_d     = last_q;
        wid_d      = wid_q;
        nq_d       = nq_q;
        cycle_done = 1'b0;
        sample_stb = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (!cfg.quiet || poll_req) begin
                    st_d   = ST_START;
                    cnt_d  = w_now - CNT_W'(1);
                    wid_d  = w_now;
                    last_d = last_slot_index(cfg.slots);
                end else if (!line_i) begin
                    st_d   = ST_START;
                    cnt_d  = w_now - CNT_W'(2);
                    wid_d  = w_now;
                    last_d = last_slot_index(cfg.slots);
                end
            end
            ST_START: begin
                if (cnt_q == '0) begin
                    st_d  = ST_START_TA;
                    cnt_d = CNT_W'(TA_CLKS - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_START_TA: begin
                if (cnt_q == '0) begin
                    st_d   = ST_SLOT;
                    cnt_d  = SLOT_LAST_PH;
                    slot_d = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_SLOT: begin
                sample_stb = (cnt_q == SLOT_LAST_PH);
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end else if (slot_q == last_q) begin
                    cycle_done = 1'b1;
                    nq_d       = cfg.quiet;
                    st_d       = ST_STOP;
                    cnt_d      = cfg.quiet ? CNT_W'(1) : CNT_W'(2);
                end else begin
                    slot_d = slot_q + SLOT_IDX_W'(1);
                    cnt_d  = SLOT_LAST_PH;
                end
            end
            ST_STOP: begin
                if (cnt_q == '0)
                    st_d = ST_STOP_TA;
                else
                    cnt_d = cnt_q - CNT_W'(1);
            end
            ST_STOP_TA: begin
                if (nq_q) begin
                    st_d = ST_IDLE;
                end else begin
                    st_d   = ST_START;
                    cnt_d  = w_now - CNT_W'(1);
                    wid_d  = w_now;
                    last_d = last_slot_index(cfg.slots);
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (!cfg.enable) begin
            st_d       = ST_IDLE;
            cycle_done = 1'b0;
            sample_stb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            slot_q <= '0;
            last_q <= last_slot_index(4'd0);
            wid_q  <= start_low_clocks(2'b00);
            nq_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            slot_q <= slot_d;
            last_q <= last_d;
            wid_q  <= wid_d;
            nq_q   <= nq_d;
        end
    end

    assign drive_low  = cfg.enable && (st_q == ST_START || st_q == ST_STOP);
    assign sample_idx = slot_q;

    // Checker state: length of the current start pulse
    logic [CNT_W-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (rst)
            low_run_q <= '0;
        else if (st_q == ST_START)
            low_run_q <= low_run_q + CNT_W'(1);
        else
            low_run_q <= '0;
    end

    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> st_q == ST_IDLE);

    a_r5_start_len: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START_TA && $past(st_q) == ST_START)
            |-> (low_run_q == wid_q || low_run_q == wid_q - CNT_W'(1)));

    a_r10_stop_len: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_STOP |-> cnt_q <= CNT_W'(2));

    a_r4_slot_range: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_SLOT |-> (slot_q <= last_q && last_q >= SLOT_IDX_W'(BASE_SLOTS - 1)));

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture
    import sirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  sample_stb,
    input  logic [SLOT_IDX_W-1:0] sample_idx,
    input  logic                  line_i,
    input  logic                  cycle_done,
    output logic [TRACKED-1:0]    lat
);
    logic [TRACKED-1:0] shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            lat      <= '0;
        end else if (!en) begin
            lat <= '0;
        end else begin
            if (sample_stb && sample_idx < SLOT_IDX_W'(TRACKED))
                shadow_q[sample_idx[3:0]] <= ~line_i;
            if (cycle_done)
                lat <= shadow_q;
        end
    end

    a_r9_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
        (en && !cycle_done) |=> $stable(lat));

    a_r1_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> lat == '0);

endmodule

// File: rtl/sirq_polarity.sv
module sirq_polarity
    import sirq_pkg::*;
(
    input  logic               en,
    input  logic [TRACKED-1:0] lat,
    input  logic [2:0]         pol,
    output logic [2:0]         low_out,
    output logic [TRACKED-4:0] hi_out
);
    genvar i;
    generate
        for (i = 0; i < 3; i++) begin : g_pol
            assign low_out[i] = (lat[i] & en) ^ pol[i];
        end
    endgenerate

    assign hi_out = en ? lat[TRACKED-1:3] : '0;
endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int TA_CLKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 poll_req,
    input  logic                 line_i,
    output logic                 line_oe,
    output logic                 line_o,
    output logic                 irq0_o,
    output logic                 irq1_o,
    output logic                 smi_o,
    output logic [TRACKED-4:0]   irq_hi_o
);
    sirq_cfg_t             cfg;
    logic                  sample_stb;
    logic [SLOT_IDX_W-1:0] sample_idx;
    logic                  cycle_done;
    logic [TRACKED-1:0]    lat;
    logic [2:0]            low_out;

    sirq_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    sirq_seq #(.TA_CLKS(TA_CLKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .line_i     (line_i),
        .poll_req   (poll_req),
        .drive_low  (line_oe),
        .sample_stb (sample_stb),
        .sample_idx (sample_idx),
        .cycle_done (cycle_done)
    );

    sirq_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg.enable),
        .sample_stb (sample_stb),
        .sample_idx (sample_idx),
        .line_i     (line_i),
        .cycle_done (cycle_done),
        .lat        (lat)
    );

    sirq_polarity u_pol (
        .en      (cfg.enable),
        .lat     (lat),
        .pol     (cfg.pol),
        .low_out (low_out),
        .hi_out  (irq_hi_o)
    );

    assign line_o = 1'b0;
    assign irq0_o = low_out[0];
    assign irq1_o = low_out[1];
    assign smi_o  = low_out[2];

    a_r12_no_sample_while_driving: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> !line_oe);

endmodule

// File: tb/sirq_host_bench.sv
module sirq_host_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        poll_req = 1'b0;
    logic        start_pull = 1'b0;
    logic        slot_low = 1'b0;
    logic        line;
    logic        line_oe, line_o, irq0_o, irq1_o, smi_o;
    logic [12:0] irq_hi_o;

    always #10 clk = ~clk;   // 50 MHz

    assign line = ~(line_oe | slot_low | start_pull);

    sirq_host u_sirq_host (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .poll_req(poll_req), .line_i(line), .line_oe(line_oe), .line_o(line_o),
        .irq0_o(irq0_o), .irq1_o(irq1_o), .smi_o(smi_o), .irq_hi_o(irq_hi_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] pattern = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] mk(input bit en, input bit q, input int slots,
                                       input int wid, input int pol);
        return {pol[2:0], wid[1:0], slots[3:0], q, en};
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [10:0] m_cfg = '0;
    bit          m_busy = 0;
    int          m_pos = 0, m_L = 4, m_n = 17, m_s0 = 0, m_sl = 3;
    bit          m_qn = 0;
    logic [15:0] m_lat = '0, m_shadow = '0;

    function automatic int width_clk(input logic [1:0] c);
        return (c == 2'b01) ? 6 : (c == 2'b10) ? 8 : 4;
    endfunction

    function automatic int slot_at(input int p);
        int rel = p - (m_L + 2);
        if (!m_busy || rel < 0 || p >= m_s0 || (rel % 3) != 0) return -1;
        return rel / 3;
    endfunction

    function automatic bit model_oe();
        return m_cfg[0] && m_busy &&
               (m_pos < m_L || (m_pos >= m_s0 && m_pos < m_s0 + m_sl));
    endfunction

    task automatic begin_cycle(input int shorten);
        m_busy = 1;
        m_pos  = 0;
        m_L    = width_clk(m_cfg[7:6]) - shorten;
        m_n    = 17 + int'(m_cfg[5:2]);
        m_s0   = m_L + 2 + 3 * m_n;
        m_sl   = 3;
    endtask

    always @(posedge clk) begin
        bit ln;
        int k;
        ln = !(model_oe() || slot_low || start_pull);
        if (rst) begin
            m_cfg = '0; m_busy = 0; m_lat = '0; m_shadow = '0; m_pos = 0;
        end else begin
            if (!m_cfg[0]) begin
                m_busy = 0;
                m_lat  = '0;
            end else if (!m_busy) begin
                if (!m_cfg[1] || poll_req) begin_cycle(0);
                else if (!ln) begin_cycle(1);
            end else begin
                k = slot_at(m_pos);
                if (k >= 0 && k < 16) m_shadow[k] = !ln;
                if (m_pos == m_s0 - 1) begin
                    m_lat = m_shadow;
                    m_qn  = m_cfg[1];
                    m_sl  = m_qn ? 2 : 3;
                end
                if (m_pos == m_s0 + m_sl) begin
                    if (m_qn) m_busy = 0;
                    else begin_cycle(0);
                end else begin
                    m_pos++;
                end
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    // ---------------- per-clock comparison and run capture ----------------
    int runs[$];
    int gaps[$];
    int run_cnt = 0, gap_cnt = 0;
    bit seen_run = 0;

    always @(negedge clk) begin
        int k;
        k = slot_at(m_pos);
        slot_low <= (k >= 0) ? pattern[k] : 1'b0;
        if (!rst) begin
            chk(line_oe == model_oe(), "R2 R4 R13 frame timing line_oe", line_oe, model_oe());
            chk(line_o == 1'b0, "R12 line_o", line_o, 0);
            chk(irq0_o == ((m_lat[0] & m_cfg[0]) ^ m_cfg[8]), "R6 R9 irq0_o", irq0_o,
                (m_lat[0] & m_cfg[0]) ^ m_cfg[8]);
            chk(irq1_o == ((m_lat[1] & m_cfg[0]) ^ m_cfg[9]), "R6 R9 irq1_o", irq1_o,
                (m_lat[1] & m_cfg[0]) ^ m_cfg[9]);
            chk(smi_o == ((m_lat[2] & m_cfg[0]) ^ m_cfg[10]), "R6 R9 smi_o", smi_o,
                (m_lat[2] & m_cfg[0]) ^ m_cfg[10]);
            chk(irq_hi_o == (m_cfg[0] ? m_lat[15:3] : 13'd0), "R8 R9 irq_hi_o",
                irq_hi_o, m_cfg[0] ? m_lat[15:3] : 13'd0);
            if (line_oe) begin
                if (gap_cnt > 0 && seen_run) gaps.push_back(gap_cnt);
                gap_cnt = 0;
                run_cnt++;
            end else begin
                if (run_cnt > 0) begin
                    runs.push_back(run_cnt);
                    seen_run = 1;
                end
                run_cnt = 0;
                gap_cnt++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [10:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_q();
        runs.delete();
        gaps.delete();
        seen_run = 0;
        gap_cnt = 0;
    endtask

    function automatic int max_run();
        int m = 0;
        foreach (runs[i]) if (runs[i] > m) m = runs[i];
        return m;
    endfunction

    function automatic bit has_gap(input int g);
        foreach (gaps[i]) if (gaps[i] == g) return 1;
        return 0;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R7: reset state
        chk(line_oe == 1'b0, "R7 reset line_oe", line_oe, 0);
        chk({irq0_o, irq1_o, smi_o} == 3'b000, "R7 reset outputs", {irq0_o, irq1_o, smi_o}, 0);
        chk(irq_hi_o == '0, "R7 reset irq_hi_o", irq_hi_o, 0);

        // R2/R8: continuous, 17 slots, IRQ0, SMI, IRQ5, IRQ15 and slot 16 asserted
        pattern = 32'h0001_8025;
        clear_q();
        write_cfg(mk(1, 0, 0, 0, 0));
        wait_clk(140);
        chk(irq0_o == 1'b1, "R8 IRQ0 slot", irq0_o, 1);
        chk(irq1_o == 1'b0, "R8 IRQ1 slot", irq1_o, 0);
        chk(smi_o == 1'b1, "R8 SMI slot", smi_o, 1);
        chk(irq_hi_o == 13'h1004, "R8 upper slots", irq_hi_o, 13'h1004);
        chk(runs.size() >= 2 && runs[0] == 4, "R5 start 4 clocks", runs.size() ? runs[0] : -1, 4);
        chk(runs.size() >= 2 && runs[1] == 3, "R10 stop continuous", runs.size() > 1 ? runs[1] : -1, 3);
        chk(has_gap(53), "R4 17 slots gap", gaps.size() ? gaps[0] : -1, 53);
        chk(has_gap(1), "R2 back to back", gaps.size() > 1 ? gaps[1] : -1, 1);

        // R5: width codes
        for (int w = 1; w < 4; w++) begin
            write_cfg(mk(1, 0, 0, w, 0));
            wait_clk(130);
            clear_q();
            wait_clk(80);
            chk(max_run() == width_clk(2'(w)), "R5 start width code", max_run(), width_clk(2'(w)));
        end

        // R4/R13: 32 slots, then shrink mid-cycle
        write_cfg(mk(1, 0, 15, 0, 0));
        wait_clk(130);
        clear_q();
        wait_clk(230);
        chk(has_gap(98), "R4 32 slots gap", gaps.size() ? gaps[0] : -1, 98);
        wait_clk(20);
        write_cfg(mk(1, 0, 0, 0, 0));
        wait_clk(200);

        // R6: polarity inversion
        write_cfg(mk(1, 0, 0, 0, 7));
        wait_clk(2);
        chk(irq0_o == 1'b0, "R6 IRQ0 inverted", irq0_o, 0);
        chk(irq1_o == 1'b1, "R6 IRQ1 inverted", irq1_o, 1);
        chk(smi_o == 1'b0, "R6 SMI inverted", smi_o, 0);

        // R3/R10: quiet mode
        write_cfg(mk(1, 1, 0, 0, 0));
        clear_q();
        wait_clk(150);
        chk(runs.size() > 0 && runs[runs.size()-1] == 2, "R10 stop quiet",
            runs.size() ? runs[runs.size()-1] : -1, 2);
        clear_q();
        wait_clk(200);
        chk(runs.size() == 0 && run_cnt == 0, "R3 quiet idle", runs.size(), 0);
        @(negedge clk); poll_req = 1'b1;
        @(negedge clk); poll_req = 1'b0;
        wait_clk(100);
        chk(runs.size() == 2 && runs[0] == 4 && runs[1] == 2, "R3 poll request cycle",
            runs.size() ? runs[0] : -1, 4);

        // R11: peripheral-initiated start
        clear_q();
        @(negedge clk); start_pull = 1'b1;
        @(negedge clk); start_pull = 1'b0;
        wait_clk(100);
        chk(runs.size() == 2 && runs[0] == 3, "R11 host completes start",
            runs.size() ? runs[0] : -1, 3);

        // R1: disable mid-cycle
        write_cfg(mk(1, 0, 0, 0, 5));
        wait_clk(30);
        write_cfg(mk(0, 0, 0, 0, 5));
        wait_clk(2);
        chk(line_oe == 1'b0, "R1 no drive when off", line_oe, 0);
        chk({smi_o, irq1_o, irq0_o} == 3'b101, "R1 inactive levels",
            {smi_o, irq1_o, irq0_o}, 5);
        chk(irq_hi_o == '0, "R1 irq_hi cleared", irq_hi_o, 0);
        clear_q();
        wait_clk(150);
        chk(runs.size() == 0 && run_cnt == 0, "R1 stays idle", runs.size(), 0);

        finish_run();
    end

endmodule